// File: doc/BRIEF.md
# Open-Row DRAM Access Controller

This controller sits between a CPU-style request port and one bank of asynchronous DRAM. It leaves the last used row open after each access. It also keeps a register that holds which row is open and a flag that says whether any row is open. Each new request's row field is compared against that register.

If the row matches, the access is a hit and only a column cycle is run. If it does not match, the access is a miss. The controller then releases the row strobe for the precharge time, strobes in the new row, and runs the column cycle. The precharge therefore falls inside the CPU's own access, so a miss costs more than a plain closed-row cycle would.

The page scheme needs no extra memory devices. Only the comparator and the open-row register are added. Precharge, row-to-column and column durations are parameters counted in clock cycles. A status output tells the CPU whether the access just completed was a hit.

Top module: `pgdram_ctrl`

## Requirements
- R1: After reset, `ras_n` and `cas_n` are high, `ready` is low, and no row is open. The first access is therefore a miss that skips precharge.
- R2: A request whose row field (`addr[ROW_W+COL_W-1:COL_W]`) equals the open row is reported with `hit`=1. Its `ready` arrives T_CAS cycles after the accepting clock edge.
- R3: A request that targets a different row while a row is open is reported with `hit`=0. `ras_n` is high for exactly T_PRE cycles of that access, and `ready` arrives T_PRE+T_RCD+T_CAS cycles after acceptance.
- R4: A request made while no row is open is reported with `hit`=0. `ras_n` stays low for the whole access, and `ready` arrives T_RCD+T_CAS cycles after acceptance.
- R5: When an access completes, and between accesses, `ras_n` stays low, so the row remains open.
- R6: `cas_n` is low for exactly T_CAS cycles in each access and only while `ras_n` is low. Between accesses `cas_n` is high.
- R7: `ready` is a single-cycle pulse, one per accepted request. A request is taken only when the controller is idle and `ready` is low.
- R8: A write drives `wdata` on `mem_dout` with `mem_we_n` low during the column cycle. A read returns `mem_din` as sampled in the last column cycle on `rdata`, so a read gives back the value last written to that address.
- R9: `mem_addr` carries the row field while the row is being strobed and the column field during the column cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until `ready` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+COL_W | Row field in the upper bits, column field in the lower bits |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Open-row hit status of the completed access |
| rdata | output | DATA_W | Read data, valid with `ready` |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | DRAM write enable, active low |
| mem_oe | output | 1 | Enables the bench/pad driver of `mem_dout` |
| mem_dout | output | DATA_W | Data to DRAM |
| mem_din | input | DATA_W | Data from DRAM |

## Verification
The `ready` pulse is due a fixed number of cycles after the accepting edge. That number is T_CAS for a hit, T_RCD+T_CAS when no row is open, and T_PRE+T_RCD+T_CAS for a miss against an open row. For each request, the driver records the index of the accepting edge and pushes the expected hit flag, latency and read data into a queue. The monitor samples at falling edges. When it sees `ready`, it compares the elapsed edge count against the expected latency. While the access is in flight, it also counts the cycles in which `ras_n` is high and `cas_n` is low, and checks those counts against T_PRE and T_CAS. A pin-level DRAM model latches the row on the falling edge of `ras_n`. Because of this, a missing precharge or a wrong address phase shows up as wrong read data.

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl #(
  parameter int ROW_W  = 5,
  parameter int COL_W  = 5,
  parameter int DATA_W = 16,
  parameter int T_PRE  = 2,
  parameter int T_RCD  = 3,
  parameter int T_CAS  = 2,
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   we,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic                   ready,
  output logic                   hit,
  output logic [DATA_W-1:0]      rdata,
  output logic [MA_W-1:0]        mem_addr,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   mem_we_n,
  output logic                   mem_oe,
  output logic [DATA_W-1:0]      mem_dout,
  input  logic [DATA_W-1:0]      mem_din
);

  localparam int TMAX = (T_PRE > T_RCD) ? ((T_PRE > T_CAS) ? T_PRE : T_CAS)
                                        : ((T_RCD > T_CAS) ? T_RCD : T_CAS);
  localparam int CW = (TMAX < 2) ? 1 : $clog2(TMAX);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ROW, S_COL} st_t;

  st_t               state;
  logic [CW-1:0]     cnt;
  logic [ROW_W-1:0]  open_row, row_q;
  logic [COL_W-1:0]  col_q;
  logic              open_vld, we_q;
  logic [DATA_W-1:0] wd_q;

  wire [ROW_W-1:0] req_row = addr[ROW_W+COL_W-1:COL_W];
  wire             accept  = (state == S_IDLE) && req && !ready;
  wire             row_hit = open_vld && (req_row == open_row);
  wire             last    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      open_row <= '0;
      open_vld <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      we_q     <= 1'b0;
      wd_q     <= '0;
      ready    <= 1'b0;
      hit      <= 1'b0;
      rdata    <= '0;
    end else begin
      ready <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          row_q <= req_row;
          col_q <= addr[COL_W-1:0];
          we_q  <= we;
          wd_q  <= wdata;
          hit   <= row_hit;
          if (row_hit) begin
            state <= S_COL;
            cnt   <= CW'(T_CAS - 1);
          end else if (open_vld) begin
            state    <= S_PRE;
            cnt      <= CW'(T_PRE - 1);
            open_vld <= 1'b0;
          end else begin
            state <= S_ROW;
            cnt   <= CW'(T_RCD - 1);
          end
        end
        S_PRE: if (last) begin
          state <= S_ROW;
          cnt   <= CW'(T_RCD - 1);
        end else cnt <= cnt - 1'b1;
        S_ROW: if (last) begin
          state    <= S_COL;
          cnt      <= CW'(T_CAS - 1);
          open_row <= row_q;
          open_vld <= 1'b1;
        end else cnt <= cnt - 1'b1;
        S_COL: if (last) begin
          state <= S_IDLE;
          ready <= 1'b1;
          if (!we_q) rdata <= mem_din;
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ras_n    = !((state == S_ROW) || (state == S_COL) || (state == S_IDLE && open_vld));
  assign cas_n    = (state != S_COL);
  assign mem_we_n = !((state == S_COL) && we_q);
  assign mem_oe   = !mem_we_n;
  assign mem_dout = wd_q;
  assign mem_addr = (state == S_COL) ? MA_W'(col_q) : MA_W'(row_q);

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n); // R6
  AST_READY_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) ready |=> !ready); // R7
  AST_HIT_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n) (ready && hit) |-> !ras_n); // R5
  AST_RAS_RISE_MISS: assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n) |-> (state == S_PRE)); // R3
  AST_WE_IN_COLUMN:  assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (!cas_n && mem_oe)); // R8
  AST_ROW_STABLE:    assert property (@(posedge clk) disable iff (!rst_n) (!cas_n && $past(!cas_n)) |-> $stable(mem_addr)); // R9

endmodule

// File: tb/tb_pgdram_ctrl.sv
module tb_pgdram_ctrl;
  localparam int RW = 5, CL = 5, DW = 16;
  localparam int TP = 2, TR = 3, TC = 2;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [RW+CL-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, mem_dout, mem_din;
  logic ready, hit, ras_n, cas_n, mem_we_n, mem_oe;
  logic [4:0] mem_addr;

  pgdram_ctrl #(.ROW_W(RW), .COL_W(CL), .DATA_W(DW), .T_PRE(TP), .T_RCD(TR), .T_CAS(TC)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .hit(hit), .rdata(rdata), .mem_addr(mem_addr), .ras_n(ras_n),
    .cas_n(cas_n), .mem_we_n(mem_we_n), .mem_oe(mem_oe), .mem_dout(mem_dout), .mem_din(mem_din));

  always #5 clk = ~clk;

  // pin-level DRAM model
  logic [DW-1:0] dmem [0:1023];
  logic [4:0] dram_row = '0;
  logic ras_d = 1'b1;
  initial for (int i = 0; i < 1024; i++) dmem[i] = '0;
  always @(posedge clk) begin
    if (ras_d && !ras_n) dram_row <= mem_addr;
    ras_d <= ras_n;
    if (!cas_n && !mem_we_n) dmem[{dram_row, mem_addr}] <= mem_dout;
  end
  assign mem_din = cas_n ? '0 : dmem[{dram_row, mem_addr}];

  // scoreboard
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  int q_start[$], q_lat[$], q_pre[$];
  bit q_hit[$], q_rd[$];
  logic [DW-1:0] q_dat[$];
  logic [DW-1:0] shadow [0:1023];
  bit ev = 1'b0;
  logic [4:0] er = '0;
  int n_ras = 0, n_cas = 0;
  bit prev_ready = 1'b0;

  initial for (int i = 0; i < 1024; i++) shadow[i] = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) if (rst_n) begin
    if (prev_ready) chk(!ready, "R7 ready single pulse", ready, 0);
    if (ready) begin
      if (q_lat.size() == 0) chk(1'b0, "R7 ready without request", 1, 0);
      else begin
        automatic int  st = q_start.pop_front();
        automatic int  lt = q_lat.pop_front();
        automatic int  pr = q_pre.pop_front();
        automatic bit  eh = q_hit.pop_front();
        automatic bit  rd = q_rd.pop_front();
        automatic logic [DW-1:0] ed = q_dat.pop_front();
        chk(hit == eh, eh ? "R2 hit flag" : "R3/R4 miss flag", hit, eh);
        chk(cyc - st == lt, eh ? "R2 hit latency" : (pr != 0 ? "R3 miss latency" : "R4 cold latency"), cyc - st, lt);
        chk(n_ras == pr, pr != 0 ? "R3 precharge cycles" : "R4 no precharge", n_ras, pr);
        chk(n_cas == TC, "R6 column strobe cycles", n_cas, TC);
        chk(!ras_n, "R5 row stays open", ras_n, 0);
        if (rd) chk(rdata == ed, "R8 R9 read data", rdata, ed);
      end
      n_ras = 0;
      n_cas = 0;
    end else if (q_start.size() > 0 && cyc >= q_start[0]) begin
      if (ras_n) n_ras++;
      if (!cas_n) n_cas++;
    end
    prev_ready = ready;
  end

  task automatic acc(input bit w, input logic [4:0] r, input logic [4:0] c, input logic [DW-1:0] d);
    automatic bit h;
    @(negedge clk);
    h = ev && (r == er);
    q_start.push_back(cyc + 1);
    q_hit.push_back(h);
    q_lat.push_back(h ? TC : (ev ? TP + TR + TC : TR + TC));
    q_pre.push_back((!h && ev) ? TP : 0);
    q_rd.push_back(!w);
    q_dat.push_back(shadow[{r, c}]);
    if (w) shadow[{r, c}] = d;
    ev = 1'b1;
    er = r;
    req = 1'b1; we = w; addr = {r, c}; wdata = d;
    do @(negedge clk); while (!ready);
    req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && !ready, "R1 reset strobes idle", {ras_n, cas_n, ready}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && !ready, "R1 idle after reset", {ras_n, cas_n, ready}, 3'b110);
    acc(1'b1, 5'd3, 5'd1, 16'hA5A5);   // R4 cold miss
    acc(1'b1, 5'd3, 5'd2, 16'h1234);   // R2 hit write
    acc(1'b0, 5'd3, 5'd1, 16'h0);      // R2 hit read
    acc(1'b1, 5'd7, 5'd0, 16'hBEEF);   // R3 miss
    acc(1'b0, 5'd3, 5'd2, 16'h0);      // R3 miss read
    acc(1'b0, 5'd3, 5'd2, 16'h0);      // R2 repeat hit
    acc(1'b1, 5'd3, 5'd31, 16'h7F01);  // R9 top column
    acc(1'b1, 5'd31, 5'd0, 16'hC3C3);  // R3 top row
    acc(1'b0, 5'd31, 5'd0, 16'h0);
    acc(1'b0, 5'd3, 5'd31, 16'h0);
    acc(1'b0, 5'd7, 5'd0, 16'h0);
    repeat (3) @(negedge clk);
    chk(!ras_n && cas_n, "R5 R6 idle with row open", {ras_n, cas_n}, 2'b01);
    chk(q_lat.size() == 0, "R7 every request completed", q_lat.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule